// File: doc/BRIEF.md
# Keyed Configuration Byte Stream

This block hands firmware a numbered set of configuration items over two narrow ports. A 16-bit control write names an item by key. After that, a byte-wide data port walks through the item one byte at a time. A hidden byte cursor moves forward on every accepted access and drops back to zero whenever a new key is chosen. Each item is described by a base pointer and a length, and is stored in one of two banks: a generic bank shared by all platforms, and a bank local to the architecture. Both the descriptors and the bytes are preloaded through a side loading path before firmware runs.

The key carries two flag bits. Bit 14 chooses the bank, and bit 15 opens the item for writing. Bits 13..0 form the index. An index at or above the item count turns the selection invalid. A writable item collects bytes from the data port. When its last byte lands, the block emits a one-cycle completion pulse along with the key that filled, and the cursor rewinds. Numeric items are stored least significant byte first, so reading them in order yields little-endian values.

Top module: `cfgs_top`

## Requirements
- R1: After reset the selection is generic key 0 with the cursor at 0, so reads stream item 0 of the generic bank without any control write. Immediately after reset, `dat_rdata` is 0 and `fill_done` is 0.
- R2: A control write always sets the cursor to 0. If the index field `ctl_key[13:0]` is at or above `N_ITEMS`, the selection becomes invalid, reads return 0 and the cursor stays at 0.
- R3: Key bit 14 selects the bank: 0 selects generic and 1 selects architecture-local. The same index in each bank names different items.
- R4: While a read is possible, `dat_rdata` shows the byte at base plus cursor, and a `dat_rd` cycle advances the cursor by one. Bytes come out in ascending address order, so a numeric item stored low byte first reads as little-endian.
- R5: A read returns 0 and leaves the cursor unchanged when the selection is invalid, when the item length is 0, or when the cursor has reached the length.
- R6: A data write is accepted only when key bit 15 is set and the cursor is below the length. An accepted write stores the byte at base plus cursor and advances the cursor. A rejected write changes neither the stored bytes nor the cursor.
- R7: A write that brings the cursor up to the length sets the cursor back to 0. On the next cycle it raises `fill_done` for exactly one cycle, with `fill_key` equal to the selected key.
- R8: Within one cycle, a control write takes precedence over data accesses, and a data write takes precedence over a data read. The losing access has no effect.
- R9: A table load sets the base and 16-bit length of the item named by bank and index. A byte load writes the store directly. At reset every length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control write strobe (selects a key) |
| ctl_key | input | 16 | Key: [15] write flag, [14] bank, [13:0] index |
| dat_rd | input | 1 | Data read strobe; consumes the shown byte |
| dat_rdata | output | 8 | Byte at the cursor, or 0 when not readable |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 8 | Data write byte |
| ld_tab_we | input | 1 | Descriptor load strobe |
| ld_tab_bank | input | 1 | Descriptor bank (1 = local) |
| ld_tab_idx | input | $clog2(N_ITEMS) | Descriptor index |
| ld_tab_base | input | $clog2(MEM_BYTES) | Item base address in the store |
| ld_tab_len | input | 16 | Item length in bytes |
| ld_mem_we | input | 1 | Byte load strobe |
| ld_mem_addr | input | $clog2(MEM_BYTES) | Byte load address |
| ld_mem_data | input | 8 | Byte load value |
| fill_done | output | 1 | One-cycle pulse when a writable item fills |
| fill_key | output | 16 | Key of the item that filled |

## Verification
The assertions check the cursor on every cycle. They confirm that it clears after each select, stays at zero while the selection is invalid, advances by exactly one on a successful read, and holds still on reads past the end and on writes to items that are not open for writing. They also confirm that a completion pulse only follows a write and always finds the cursor rewound. Only the bench scenarios can show the data itself: the little-endian byte order, the separation between banks, the bytes stored by writes and read back after a reselect, and the pulse arriving in the right cycle with the right key.

// File: rtl/cfgs_pkg.sv
// Package: shared widths and key bit positions for the keyed config stream.
// Assumes a 16-bit key whose two top bits are flags.
package cfgs_pkg;
    localparam int KEY_W    = 16;
    localparam int LEN_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int WR_BIT   = 15;  // item accepts data writes
    localparam int BANK_BIT = 14;  // 1 = architecture-local bank
    localparam int IDX_W    = 14;  // index field width
    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cfgs_entry_tab.sv
// Module: descriptor table holding base and length per item, two banks.
// Assumes the lookup index is in range whenever the selection is valid;
// out-of-range lookups return a zero descriptor.
module cfgs_entry_tab
    import cfgs_pkg::*;
#(
    parameter int N_ITEMS = 8,
    parameter int AW      = 8,
    parameter int IW      = $clog2(N_ITEMS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic          ld_bank,
    input  logic [IW-1:0] ld_idx,
    input  logic [AW-1:0] ld_base,
    input  len_t          ld_len,
    input  logic          rd_bank,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_base,
    output len_t          rd_len
);
    logic [AW-1:0] base_q [2][N_ITEMS];
    len_t          len_q  [2][N_ITEMS];

    // Load descriptors; all lengths clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < N_ITEMS; i++) begin
                    base_q[b][i] <= '0;
                    len_q[b][i]  <= '0;
                end
        end else if (ld_we && (int'(ld_idx) < N_ITEMS)) begin
            base_q[ld_bank][ld_idx] <= ld_base;
            len_q[ld_bank][ld_idx]  <= ld_len;
        end
    end

    // Look up the selected descriptor.
    always_comb begin
        rd_base = '0;
        rd_len  = '0;
        if (int'(rd_idx) < N_ITEMS) begin
            rd_base = base_q[rd_bank][rd_idx];
            rd_len  = len_q[rd_bank][rd_idx];
        end
    end
endmodule

// File: rtl/cfgs_byte_store.sv
// Module: byte store with a load port and a device write port, async read.
// Assumes the load port wins when both ports write in the same cycle.
module cfgs_byte_store
    import cfgs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  byte_t         a_data,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  byte_t         b_data,
    input  logic [AW-1:0] rd_addr,
    output byte_t         rd_data
);
    byte_t mem [DEPTH];

    // Write bytes, load port first.
    always_ff @(posedge clk) begin
        if (a_we)      mem[a_addr] <= a_data;
        else if (b_we) mem[b_addr] <= b_data;
    end

    // Combinational read at the cursor address.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cfgs_cursor.sv
// Module: key selection and byte cursor, access gating and fill pulse.
// Assumes ent_len/ent_base describe the currently selected item.
module cfgs_cursor
    import cfgs_pkg::*;
#(
    parameter int N_ITEMS = 8,
    parameter int AW      = 8,
    parameter int IW      = $clog2(N_ITEMS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_we,
    input  key_t          sel_key,
    input  logic          rd_req,
    input  logic          wr_req,
    input  len_t          ent_len,
    input  logic [AW-1:0] ent_base,
    output logic          cur_bank,
    output logic [IW-1:0] cur_idx,
    output logic          readable,
    output logic          wr_go,
    output logic [AW-1:0] mem_addr,
    output logic          fill_done,
    output key_t          fill_key
);
    key_t key_q;
    logic ok_q;
    len_t off_q;
    logic done_q;
    key_t done_key_q;

    logic in_range, writable;
    len_t off_inc;

    assign in_range = (sel_key[IDX_W-1:0] < IDX_W'(N_ITEMS));
    assign readable = ok_q && (off_q < ent_len);
    assign writable = ok_q && key_q[WR_BIT] && (off_q < ent_len);
    assign off_inc  = off_q + 1'b1;
    assign wr_go    = wr_req && !sel_we && writable;
    assign cur_bank = key_q[BANK_BIT];
    assign cur_idx  = key_q[IW-1:0];
    assign mem_addr = ent_base + off_q[AW-1:0];
    assign fill_done = done_q;
    assign fill_key  = done_key_q;

    // Select, advance the cursor, and raise the fill pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q      <= '0;
            ok_q       <= 1'b1;
            off_q      <= '0;
            done_q     <= 1'b0;
            done_key_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (sel_we) begin
                key_q <= sel_key;
                ok_q  <= in_range;
                off_q <= '0;
            end else if (wr_req) begin
                if (writable) begin
                    if (off_inc == ent_len) begin
                        off_q      <= '0;
                        done_q     <= 1'b1;
                        done_key_q <= key_q;
                    end else begin
                        off_q <= off_inc;
                    end
                end
            end else if (rd_req && readable) begin
                off_q <= off_inc;
            end
        end
    end

    // R2
    sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> off_q == '0);
    // R2
    invalid_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_q |-> off_q == '0);
    // R4
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !sel_we && !wr_req && ok_q && off_q < ent_len)
        |=> off_q == LEN_W'($past(off_q) + 1));
    // R5
    read_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !sel_we && !wr_req && off_q >= ent_len) |=> $stable(off_q));
    // R6
    write_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !sel_we && !key_q[WR_BIT]) |=> $stable(off_q));
    // R7
    fill_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> off_q == '0);
    // R7
    fill_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> $past(wr_req));
endmodule

// File: rtl/cfgs_top.sv
// Module: keyed configuration byte stream, top level.
// Assumes items are loaded before firmware accesses them and that
// base + length of every item fits inside the byte store.
module cfgs_top
    import cfgs_pkg::*;
#(
    parameter int N_ITEMS   = 8,
    parameter int MEM_BYTES = 256,
    localparam int IW = $clog2(N_ITEMS),
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [15:0]   ctl_key,
    input  logic          dat_rd,
    output logic [7:0]    dat_rdata,
    input  logic          dat_we,
    input  logic [7:0]    dat_wdata,
    input  logic          ld_tab_we,
    input  logic          ld_tab_bank,
    input  logic [IW-1:0] ld_tab_idx,
    input  logic [AW-1:0] ld_tab_base,
    input  logic [15:0]   ld_tab_len,
    input  logic          ld_mem_we,
    input  logic [AW-1:0] ld_mem_addr,
    input  logic [7:0]    ld_mem_data,
    output logic          fill_done,
    output logic [15:0]   fill_key
);
    logic          cur_bank, readable, wr_go;
    logic [IW-1:0] cur_idx;
    logic [AW-1:0] ent_base, mem_addr;
    len_t          ent_len;
    byte_t         mem_byte;

    cfgs_entry_tab #(.N_ITEMS(N_ITEMS), .AW(AW)) u_tab (
        .clk(clk), .rst_n(rst_n),
        .ld_we(ld_tab_we), .ld_bank(ld_tab_bank), .ld_idx(ld_tab_idx),
        .ld_base(ld_tab_base), .ld_len(ld_tab_len),
        .rd_bank(cur_bank), .rd_idx(cur_idx),
        .rd_base(ent_base), .rd_len(ent_len)
    );

    cfgs_byte_store #(.DEPTH(MEM_BYTES)) u_store (
        .clk(clk),
        .a_we(ld_mem_we), .a_addr(ld_mem_addr), .a_data(ld_mem_data),
        .b_we(wr_go), .b_addr(mem_addr), .b_data(dat_wdata),
        .rd_addr(mem_addr), .rd_data(mem_byte)
    );

    cfgs_cursor #(.N_ITEMS(N_ITEMS), .AW(AW)) u_cur (
        .clk(clk), .rst_n(rst_n),
        .sel_we(ctl_we), .sel_key(ctl_key),
        .rd_req(dat_rd), .wr_req(dat_we),
        .ent_len(ent_len), .ent_base(ent_base),
        .cur_bank(cur_bank), .cur_idx(cur_idx),
        .readable(readable), .wr_go(wr_go), .mem_addr(mem_addr),
        .fill_done(fill_done), .fill_key(fill_key)
    );

    // Zero the data port whenever no byte is available.
    assign dat_rdata = readable ? mem_byte : 8'h00;

    // R7
    pulse_single_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> fill_key[WR_BIT]);
endmodule

// File: tb/test_cfgs_top.sv
`timescale 1ns/1ps
module test_cfgs_top;
    localparam int N_ITEMS = 8;
    localparam int MEM_BYTES = 256;
    localparam int IW = $clog2(N_ITEMS);
    localparam int AW = $clog2(MEM_BYTES);

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_we = 0, dat_rd = 0, dat_we = 0, ld_tab_we = 0, ld_tab_bank = 0, ld_mem_we = 0;
    logic [15:0] ctl_key = 0, ld_tab_len = 0;
    logic [7:0] dat_wdata = 0, ld_mem_data = 0, dat_rdata;
    logic [IW-1:0] ld_tab_idx = 0;
    logic [AW-1:0] ld_tab_base = 0, ld_mem_addr = 0;
    logic fill_done;
    logic [15:0] fill_key;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    cfgs_top i_cfgs_top (.*);

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compare each plain read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && dat_rd && !ctl_we && !dat_we) begin
            if (exp_q.size() == 0) check(0, "scoreboard", dat_rdata, 0);
            else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(dat_rdata == e, t, dat_rdata, e);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        ctl_we = 0; dat_rd = 0; dat_we = 0; ld_tab_we = 0; ld_mem_we = 0;
    endtask
    task automatic sel(logic [15:0] k);
        @(posedge clk); #1; ctl_we = 1; ctl_key = k; step();
    endtask
    task automatic rd(logic [7:0] e, string t);
        @(posedge clk); #1; exp_q.push_back(e); tag_q.push_back(t); dat_rd = 1; step();
    endtask
    task automatic wr(logic [7:0] d);
        @(posedge clk); #1; dat_we = 1; dat_wdata = d; step();
    endtask
    task automatic ld_tab(bit bank, int idx, int base, int len);
        @(posedge clk); #1; ld_tab_we = 1; ld_tab_bank = bank;
        ld_tab_idx = IW'(idx); ld_tab_base = AW'(base); ld_tab_len = 16'(len); step();
    endtask
    task automatic ld_byte(int a, logic [7:0] d);
        @(posedge clk); #1; ld_mem_we = 1; ld_mem_addr = AW'(a); ld_mem_data = d; step();
    endtask
    task automatic chk_done(bit exp, logic [15:0] k, string t);
        @(negedge clk);
        check(fill_done == exp, t, fill_done, exp);
        if (exp) check(fill_key == k, t, fill_key, k);
    endtask

    initial begin
        #(5.0 * 200000);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(dat_rdata == 8'h00, "R1", dat_rdata, 0);
        check(fill_done == 1'b0, "R1", fill_done, 0);
        // R9 loads
        for (int i = 0; i < 4; i++) ld_byte(i, 8'h11 + 8'(i));
        ld_tab(0, 0, 0, 4);
        ld_byte(4, 8'hEF); ld_byte(5, 8'hBE); ld_tab(0, 1, 4, 2);
        for (int i = 0; i < 3; i++) ld_byte(8 + i, 8'hA1 + 8'(i));
        ld_tab(1, 1, 8, 3);
        for (int i = 0; i < 3; i++) ld_byte(16 + i, 8'h21 + 8'(i));
        ld_tab(0, 2, 16, 3);
        ld_tab(0, 3, 24, 0);
        ld_byte(32, 8'h00); ld_tab(1, 5, 32, 1);
        // R1 stream item 0 without a select
        rd(8'h11, "R1"); rd(8'h12, "R1"); rd(8'h13, "R1"); rd(8'h14, "R1");
        // R5 past the end
        rd(8'h00, "R5"); rd(8'h00, "R5");
        // R2 reselect clears cursor
        sel(16'h0000); rd(8'h11, "R2"); rd(8'h12, "R2");
        sel(16'h0000); rd(8'h11, "R2");
        // R4 little-endian numeric item
        sel(16'h0001); rd(8'hEF, "R4"); rd(8'hBE, "R4"); rd(8'h00, "R5");
        // R3 bank bit
        sel(16'h4001); rd(8'hA1, "R3"); rd(8'hA2, "R3"); rd(8'hA3, "R3");
        sel(16'h0001); rd(8'hEF, "R3");
        // R2 invalid index
        sel(16'h0008); rd(8'h00, "R2"); rd(8'h00, "R2");
        sel(16'h4009); rd(8'h00, "R2");
        // R5 zero-length item
        sel(16'h0003); rd(8'h00, "R5");
        // R6 write without the flag has no effect
        sel(16'h0002); wr(8'h55); chk_done(0, 0, "R6");
        rd(8'h21, "R6"); rd(8'h22, "R6");
        // R7 fill a writable item
        sel(16'h8002); wr(8'h61); chk_done(0, 0, "R7"); wr(8'h62); wr(8'h63);
        chk_done(1, 16'h8002, "R7");
        step(); chk_done(0, 0, "R7");
        rd(8'h61, "R7");              // rewound, stored
        wr(8'h72);                    // offset 1 accepted
        sel(16'h0002); rd(8'h61, "R6"); rd(8'h72, "R6"); rd(8'h63, "R6");
        // R6 write at end rejected
        sel(16'h8002); rd(8'h61, "R6"); rd(8'h72, "R6"); rd(8'h63, "R6");
        wr(8'h99); chk_done(0, 0, "R6");
        sel(16'h0002); rd(8'h61, "R6"); rd(8'h72, "R6"); rd(8'h63, "R6");
        // R8 select beats read
        @(posedge clk); #1; ctl_we = 1; ctl_key = 16'h0001; dat_rd = 1; step();
        rd(8'hEF, "R8");
        // R8 write beats read
        sel(16'h8002);
        @(posedge clk); #1; dat_we = 1; dat_wdata = 8'h44; dat_rd = 1; step();
        rd(8'h72, "R8");
        sel(16'h0002); rd(8'h44, "R8");
        // R7 one-byte local writable item pulses every write
        sel(16'hC005); wr(8'h77); chk_done(1, 16'hC005, "R7");
        wr(8'h78); chk_done(1, 16'hC005, "R7");
        sel(16'h4005); rd(8'h78, "R7");
        step(); step();
        check(exp_q.size() == 0, "scoreboard", exp_q.size(), 0);
        finish_run();
    end
endmodule